// File: doc/BRIEF.md
# Power-Fail Write-Protect Controller

This block supervises a battery-backed static RAM. It watches two supply flags from analog comparators: one that says the main supply has dropped under the fail threshold, and one that says it has dropped under the level at which the cell should take over. It also watches the memory's active-low chip-enable, write-enable and output-enable strobes. From these it drives four registered controls: a write block for the array, a tristate request for the data pins, a select that moves the array onto the backup cell, and a latch that connects the cell to the array once main power has been seen for the first time.

While power is good the memory behaves as an ordinary SRAM. When the fail flag rises, the controller lets an access already in progress run to its end. If that access does not end within a bounded time, protection is forced anyway. After power returns, protection is held for a long recovery window so the host can settle. Both intervals are counters whose lengths are parameters given in clock cycles. A fast-simulation switch shortens both by a right shift.

Top module: `pfwp_ctrl`

## Requirements
- R1: On synchronous reset the write block and the tristate request are 1, the backup select is 0 and the cell link is 0.
- R2: After reset the cell link stays 0 while the fail flag is high, and the backup select stays 0 even if the low flag is high. The link becomes 1 three clock edges after the fail flag is first seen low.
- R3: With power good, the tristate request is 0 only for a read (chip enable 0, write enable 1, output enable 0). A change on the strobes shows on the output one clock edge later.
- R4: If no access is in progress, the write block and the tristate request are 1 three edges after the fail flag rises, with two of those edges spent in the synchronizer. While protected, the strobes have no effect on either output.
- R5: An access is in progress when chip enable is 0 and either write enable or output enable is 0. If one is in progress when the synchronized fail flag is seen, the write block stays 0 and reads still drive the pins until the access ends. Protection applies at the next edge after that.
- R6: If the access is still in progress WPT cycles after the controller started waiting for it to end, the write block is forced to 1.
- R7: The backup select becomes 1 three edges after the low flag rises and returns to 0 three edges after it falls. While it is 1, the write block and the tristate request are both 1.
- R8: After the fail flag falls, the write block stays 1 for 2+REC edges and drops at edge 3+REC.
- R9: If the fail flag rises again during the recovery window, the write block stays 1 on every cycle, and the full recovery window starts over once the flag falls again.
- R10: Once set, the cell link stays 1 across later fail and backup episodes until reset.
- R11: The effective counts are REC = REC_CYCLES and WPT = WPT_CYCLES when fast simulation is off. When it is on, each count is shifted right by FAST_SHIFT and truncated, with a minimum of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_fail_i | input | 1 | Asynchronous flag: supply below fail threshold |
| supply_low_i | input | 1 | Asynchronous flag: supply below switch-over level |
| ce_n_i | input | 1 | Chip enable, active low |
| we_n_i | input | 1 | Write enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| wr_block_o | output | 1 | Write protection for the array |
| dq_hiz_o | output | 1 | Data pins to high impedance |
| bkp_sel_o | output | 1 | Array powered from the backup cell |
| cell_link_o | output | 1 | Backup cell connected to the array |

## Verification
The bench builds the controller with REC_CYCLES=4000, WPT_CYCLES=600, fast simulation on and a shift of 6. This gives an effective recovery window of 62 cycles and an access timeout of 9 cycles. With these values the bench can run the whole recovery window several times, including a restart when the fail flag rises again during recovery. It can also reach the forced-protection point while a write is held open, and still measure the exact edge on which each output changes.

// File: rtl/pfwp_pkg.sv
package pfwp_pkg;

  typedef enum logic [2:0] {
    ST_ISOLATED,
    ST_NORMAL,
    ST_DRAIN,
    ST_PROTECT,
    ST_BACKUP,
    ST_RECOVER
  } pf_state_e;

  function automatic int unsigned scale_cyc(input int unsigned cyc,
                                            input bit fast,
                                            input int unsigned sh);
    int unsigned v;
    v = fast ? (cyc >> sh) : cyc;
    return (v == 0) ? 1 : v;
  endfunction

endpackage

// File: rtl/pfwp_sync.sv
module pfwp_sync #(
  parameter int W       = 2,
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= {STAGES{ {W{RST_VAL}} }};
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];

endmodule

// File: rtl/pfwp_timer.sv
module pfwp_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic [CW-1:0] last_i,
  output logic          done_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) cnt_q <= '0;
    else if (en_i)    cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = en_i && (cnt_q == last_i);

endmodule

// File: rtl/pfwp_ctrl.sv
module pfwp_ctrl #(
  parameter int unsigned REC_CYCLES = 8000000,
  parameter int unsigned WPT_CYCLES = 10000,
  parameter bit          FAST_SIM   = 1'b0,
  parameter int unsigned FAST_SHIFT = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_fail_i,
  input  logic supply_low_i,
  input  logic ce_n_i,
  input  logic we_n_i,
  input  logic oe_n_i,
  output logic wr_block_o,
  output logic dq_hiz_o,
  output logic bkp_sel_o,
  output logic cell_link_o
);
  import pfwp_pkg::*;

  localparam int unsigned REC_EFF = scale_cyc(REC_CYCLES, FAST_SIM, FAST_SHIFT);
  localparam int unsigned WPT_EFF = scale_cyc(WPT_CYCLES, FAST_SIM, FAST_SHIFT);
  localparam int unsigned MAX_EFF = (REC_EFF > WPT_EFF) ? REC_EFF : WPT_EFF;
  localparam int          CW      = $clog2(MAX_EFF + 1);
  localparam logic [CW-1:0] REC_LAST = CW'(REC_EFF - 1);
  localparam logic [CW-1:0] WPT_LAST = CW'(WPT_EFF - 1);

  logic [1:0] flags_s;
  logic       fail_s;
  logic       low_s;

  pfwp_sync #(.W(2), .STAGES(2), .RST_VAL(1'b1)) sync_i (
    .clk (clk),
    .rst (rst),
    .d_i ({supply_low_i, supply_fail_i}),
    .q_o (flags_s)
  );
  assign fail_s = flags_s[0];
  assign low_s  = flags_s[1];

  pf_state_e state_q, state_d;
  logic      access, rd_req, tmr_done, tmr_en, tmr_clr;
  logic [CW-1:0] tmr_last;

  assign access = !ce_n_i && (!we_n_i || !oe_n_i);
  assign rd_req = !ce_n_i && we_n_i && !oe_n_i;

  assign tmr_en   = (state_q == ST_DRAIN) || (state_q == ST_RECOVER);
  assign tmr_clr  = (state_d != state_q);
  assign tmr_last = (state_q == ST_DRAIN) ? WPT_LAST : REC_LAST;

  pfwp_timer #(.CW(CW)) tmr_i (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (tmr_clr),
    .en_i   (tmr_en),
    .last_i (tmr_last),
    .done_o (tmr_done)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_ISOLATED: if (!fail_s) state_d = ST_RECOVER;
      ST_NORMAL:   if (fail_s)  state_d = access ? ST_DRAIN : ST_PROTECT;
      ST_DRAIN:    if (!access || tmr_done) state_d = ST_PROTECT;
      ST_PROTECT: begin
        if (low_s)        state_d = ST_BACKUP;
        else if (!fail_s) state_d = ST_RECOVER;
      end
      ST_BACKUP:   if (!low_s) state_d = ST_PROTECT;
      ST_RECOVER: begin
        if (low_s)         state_d = ST_BACKUP;
        else if (fail_s)   state_d = ST_PROTECT;
        else if (tmr_done) state_d = ST_NORMAL;
      end
      default:     state_d = ST_ISOLATED;
    endcase
  end

  logic open_d;
  assign open_d = (state_d == ST_NORMAL) || (state_d == ST_DRAIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_ISOLATED;
      wr_block_o  <= 1'b1;
      dq_hiz_o    <= 1'b1;
      bkp_sel_o   <= 1'b0;
      cell_link_o <= 1'b0;
    end else begin
      state_q     <= state_d;
      wr_block_o  <= !open_d;
      dq_hiz_o    <= open_d ? !rd_req : 1'b1;
      bkp_sel_o   <= (state_d == ST_BACKUP);
      cell_link_o <= cell_link_o ||
                     ((state_q == ST_ISOLATED) && (state_d != ST_ISOLATED));
    end
  end

endmodule

// File: rtl/pfwp_ctrl_chk.sv
module pfwp_ctrl_chk #(
  parameter int unsigned REC_CYCLES = 8000000,
  parameter int unsigned WPT_CYCLES = 10000,
  parameter bit          FAST_SIM   = 1'b0,
  parameter int unsigned FAST_SHIFT = 10
) (
  input logic clk,
  input logic rst,
  input logic fail_s,
  input logic wr_block_o,
  input logic dq_hiz_o,
  input logic bkp_sel_o,
  input logic cell_link_o
);
  import pfwp_pkg::*;

  localparam int unsigned REC_EFF = scale_cyc(REC_CYCLES, FAST_SIM, FAST_SHIFT);
  localparam int unsigned WPT_EFF = scale_cyc(WPT_CYCLES, FAST_SIM, FAST_SHIFT);

  logic [31:0] open_run_q;
  logic [31:0] quiet_run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_run_q  <= '0;
      quiet_run_q <= '0;
    end else begin
      if (fail_s && !wr_block_o) open_run_q <= (open_run_q == '1) ? open_run_q : open_run_q + 1;
      else                       open_run_q <= '0;
      if (!fail_s) quiet_run_q <= (quiet_run_q == '1) ? quiet_run_q : quiet_run_q + 1;
      else         quiet_run_q <= '0;
    end
  end

  AST_BLOCK_HIZ: assert property (@(posedge clk) disable iff (rst)
    wr_block_o |-> dq_hiz_o); // R4

  AST_DRAIN_BOUND: assert property (@(posedge clk) disable iff (rst)
    (fail_s && !wr_block_o) |-> (open_run_q <= WPT_EFF)); // R6

  AST_BKP_PROTECT: assert property (@(posedge clk) disable iff (rst)
    bkp_sel_o |-> (wr_block_o && dq_hiz_o)); // R7

  AST_RECOVER_HOLD: assert property (@(posedge clk) disable iff (rst)
    $fell(wr_block_o) |-> (quiet_run_q >= REC_EFF)); // R8

  AST_LINK_STICKY: assert property (@(posedge clk) disable iff (rst)
    cell_link_o |=> cell_link_o); // R10

  AST_NO_SEL_UNLINKED: assert property (@(posedge clk) disable iff (rst)
    !cell_link_o |-> !bkp_sel_o); // R2

endmodule

bind pfwp_ctrl pfwp_ctrl_chk #(
  .REC_CYCLES (REC_CYCLES),
  .WPT_CYCLES (WPT_CYCLES),
  .FAST_SIM   (FAST_SIM),
  .FAST_SHIFT (FAST_SHIFT)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .fail_s      (fail_s),
  .wr_block_o  (wr_block_o),
  .dq_hiz_o    (dq_hiz_o),
  .bkp_sel_o   (bkp_sel_o),
  .cell_link_o (cell_link_o)
);

// File: tb/pfwp_ctrl_tb_top.sv
module pfwp_ctrl_tb_top;

  localparam int unsigned REC_CYC = 4000;
  localparam int unsigned WPT_CYC = 600;
  localparam int unsigned SHIFT   = 6;
  localparam int REC_E = ((REC_CYC >> SHIFT) == 0) ? 1 : int'(REC_CYC >> SHIFT);
  localparam int WPT_E = ((WPT_CYC >> SHIFT) == 0) ? 1 : int'(WPT_CYC >> SHIFT);

  // {ce_n, we_n, oe_n, expected dq_hiz} with power good
  localparam logic [3:0] VEC [8] = '{
    4'b1111, 4'b1101, 4'b1011, 4'b1001,
    4'b0100, 4'b0111, 4'b0001, 4'b0011
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fail = 1'b1, low = 1'b1;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic wr_block, dq_hiz, bkp_sel, cell_link;

  int n_chk = 0;
  int n_fail = 0;
  bit reported = 1'b0;

  always #5 clk = ~clk;

  pfwp_ctrl #(
    .REC_CYCLES (REC_CYC),
    .WPT_CYCLES (WPT_CYC),
    .FAST_SIM   (1'b1),
    .FAST_SHIFT (SHIFT)
  ) dut_i (
    .clk           (clk),
    .rst           (rst),
    .supply_fail_i (fail),
    .supply_low_i  (low),
    .ce_n_i        (ce_n),
    .we_n_i        (we_n),
    .oe_n_i        (oe_n),
    .wr_block_o    (wr_block),
    .dq_hiz_o      (dq_hiz),
    .bkp_sel_o     (bkp_sel),
    .cell_link_o   (cell_link)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    end
  endtask

  task automatic idle();
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic recover_full(input string req);
    fail = 1'b0;
    tick(2 + REC_E);
    chk(req, wr_block, 1'b1);
    tick(1);
    chk(req, wr_block, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    report();
    $finish;
  end

  initial begin
    tick(3);
    chk("R1 block", wr_block, 1'b1);
    chk("R1 hiz", dq_hiz, 1'b1);
    chk("R1 sel", bkp_sel, 1'b0);
    chk("R1 link", cell_link, 1'b0);

    rst = 1'b0;
    tick(6);
    chk("R2 link held", cell_link, 1'b0);
    chk("R2 sel isolated", bkp_sel, 1'b0);
    chk("R2 block", wr_block, 1'b1);

    fail = 1'b0; low = 1'b0;
    tick(2);
    chk("R2 link early", cell_link, 1'b0);
    tick(1);
    chk("R2 link set", cell_link, 1'b1);
    tick(REC_E - 1);
    chk("R8 R11 hold", wr_block, 1'b1);
    tick(1);
    chk("R8 R11 release", wr_block, 1'b0);

    for (int i = 0; i < 8; i++) begin
      ce_n = VEC[i][3]; we_n = VEC[i][2]; oe_n = VEC[i][1];
      tick(1);
      chk("R3 decode", dq_hiz, VEC[i][0]);
      chk("R3 open", wr_block, 1'b0);
    end

    // R4: idle fail, strobes ignored
    idle();
    fail = 1'b1;
    tick(2);
    chk("R4 before", wr_block, 1'b0);
    tick(1);
    chk("R4 block", wr_block, 1'b1);
    chk("R4 hiz", dq_hiz, 1'b1);
    ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0;
    tick(2);
    chk("R4 read ignored", dq_hiz, 1'b1);
    ce_n = 1'b0; we_n = 1'b0;
    tick(1);
    chk("R4 write ignored", wr_block, 1'b1);
    idle();
    recover_full("R8");

    // R5: write in progress drains
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    fail = 1'b1;
    tick(3);
    chk("R5 write drain", wr_block, 1'b0);
    tick(2);
    chk("R5 write drain", wr_block, 1'b0);
    idle();
    tick(1);
    chk("R5 write end", wr_block, 1'b1);
    recover_full("R8");

    // R5: read in progress drains and still drives
    ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0;
    fail = 1'b1;
    tick(3);
    chk("R5 read drain", wr_block, 1'b0);
    chk("R5 read drives", dq_hiz, 1'b0);
    idle();
    tick(1);
    chk("R5 read end", wr_block, 1'b1);
    chk("R5 read end hiz", dq_hiz, 1'b1);
    recover_full("R8");

    // R6: timeout
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    fail = 1'b1;
    tick(2 + WPT_E);
    chk("R6 R11 before", wr_block, 1'b0);
    tick(1);
    chk("R6 R11 forced", wr_block, 1'b1);
    tick(2);
    chk("R6 held", wr_block, 1'b1);
    idle();

    // R7: backup select
    low = 1'b1;
    tick(2);
    chk("R7 early", bkp_sel, 1'b0);
    tick(1);
    chk("R7 sel", bkp_sel, 1'b1);
    chk("R7 block", wr_block, 1'b1);
    chk("R7 hiz", dq_hiz, 1'b1);
    low = 1'b0;
    tick(2);
    chk("R7 still", bkp_sel, 1'b1);
    tick(1);
    chk("R7 back", bkp_sel, 1'b0);
    chk("R10 link", cell_link, 1'b1);

    // R9: fail again during recovery
    fail = 1'b0;
    tick(3 + 10);
    chk("R9 in recovery", wr_block, 1'b1);
    fail = 1'b1;
    for (int k = 0; k < 6; k++) begin
      tick(1);
      chk("R9 no glitch", wr_block, 1'b1);
    end
    recover_full("R9");
    chk("R10 link end", cell_link, 1'b1);

    report();
    $finish;
  end

endmodule